// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Interrupt Detection

This block controls a port of up to eight general-purpose pins. Software reaches it over a simple synchronous read/write bus. Each pin has its own 32-byte window of registers: a configuration word, a debounce threshold, a sampled input level, a float control, and a drive level. Writing to a per-pin clear location acknowledges that pin's interrupt.

Each pin input passes through a two-stage synchronizer and then a threshold debouncer. An interrupt detector watches the filtered level. It can detect nothing, a level, one edge or both edges, and a polarity bit chooses rising or falling edge, or active-high or active-low level. A detection sets a per-pin pending flag. A port-wide status word at byte 0x100 collects the pending flags. A single interrupt line is raised while any pin is pending and has both its interrupt enable and its pin enable set.

Bus transactions: a write takes effect on the rising clock edge where `req_i` and `we_i` are both high. A read samples `addr_i` on the edge where `req_i` is high and `we_i` is low, and `rdata_o` holds the result from that edge until the next read. Unmapped addresses read as zero, and writes to them are dropped.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero, `pad_oe_o` is all zero and `irq_o` is low.
- R2: Pin n's window starts at byte n*0x20. Inside it, the configuration word is at +0x00 and has these fields: bit0 pin enable, bit1 output direction (1 = output), bits[3:2] trigger type, bit4 polarity, bit6 interrupt enable. It reads back exactly those bits, and every other bit reads 0. The debounce word at +0x04 stores bits[7:0].
- R3: `pad_oe_o[n]` is high exactly when pin n is enabled, set as an output and not floated, where float is bit0 of +0x0C. `pad_o[n]` follows bit0 of +0x10.
- R4: Bit0 of +0x08 returns the synchronized, filtered level of `pad_i[n]`, whatever the pin's direction or enable.
- R5: With threshold T, a new input level is accepted only after it has been stable for T+1 cycles after the two-flop synchronizer. Shorter pulses are dropped, and T=0 accepts a level after one cycle.
- R6: Trigger type 2 is a single edge. Polarity 1 detects rising edges and polarity 0 detects falling edges. The pending flag stays set until it is cleared.
- R7: Trigger type 3 detects both edges, whatever the polarity.
- R8: Trigger type 1 is a level trigger, with polarity 1 active-high and polarity 0 active-low. A cleared flag sets again one cycle later if the active level is still there.
- R9: Writing a word with bit0 = 1 to +0x14 clears pin n's pending flag on that edge. A write with bit0 = 0 has no effect.
- R10: The word at 0x100 holds pin n's pending flag in bit n, and bits at and above the pin count read 0.
- R11: `irq_o` is the OR over all pins of (pending AND interrupt enable AND pin enable).
- R12: Trigger type 0 never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| pad_i | input | NUM_PINS | Pin levels from the pads |
| pad_o | output | NUM_PINS | Drive levels to the pads |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The debouncer assertion assumes `pad_i` is synchronous enough for the two flops to settle: each bench pin change is made at a falling edge and held for whole cycles. The pending-flag properties assume clear strobes come only from bus writes, so the bench issues each request for exactly one cycle and never overlaps a clear with a configuration change on the same pin. Status-word properties assume reads target the exact status address, and the bench issues reads only to mapped offsets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // packed so that {ie, pol, trig, dir, en} matches write bits {6, 4:0}
  typedef struct packed {
    logic  irq_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  en;
  } pin_cfg_t;

  localparam int unsigned WIN_SHIFT = 5;
  localparam logic [WIN_SHIFT-1:0] OFS_CFG  = 5'h00;
  localparam logic [WIN_SHIFT-1:0] OFS_DEB  = 5'h04;
  localparam logic [WIN_SHIFT-1:0] OFS_IN   = 5'h08;
  localparam logic [WIN_SHIFT-1:0] OFS_OCTL = 5'h0C;
  localparam logic [WIN_SHIFT-1:0] OFS_OVAL = 5'h10;
  localparam logic [WIN_SHIFT-1:0] OFS_CLR  = 5'h14;

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned DEB_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pad_i,
  input  logic [DEB_W-1:0] thr_i,
  output logic             level_o
);

  logic [1:0]       sync_q;
  logic [DEB_W-1:0] cnt_q;
  logic             lvl_q;
  logic             samp;

  assign samp    = sync_q[1];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], pad_i};
  end

  // accept after thr+1 consecutive mismatching samples; thr=0 is one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (samp == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= thr_i) begin
      lvl_q <= samp;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DEB_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> (lvl_q == $past(samp))); // R5

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  level_i,
  input  trig_e trig_i,
  input  logic  pol_i,
  input  logic  clr_i,
  output logic  pend_o
);

  logic prev_q;
  logic pend_q;
  logic rise, fall, hit;

  assign rise   = level_i & ~prev_q;
  assign fall   = ~level_i & prev_q;
  assign pend_o = pend_q;

  always_comb begin
    unique case (trig_i)
      TRIG_LEVEL: hit = (level_i == pol_i);
      TRIG_EDGE:  hit = pol_i ? rise : fall;
      TRIG_BOTH:  hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // clear wins over a same-cycle hit; level re-arms on the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      pend_q <= clr_i ? 1'b0 : (pend_q | hit);
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q); // R6

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q); // R9

  AST_NONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == TRIG_NONE && !pend_q) |=> !pend_q); // R12

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEB_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);

  localparam int unsigned IDX_W = ADDR_W - WIN_SHIFT;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(12'h100);

  logic [IDX_W-1:0]     win_idx;
  logic [WIN_SHIFT-1:0] reg_ofs;
  logic                 win_hit;
  logic                 wr_en;
  logic                 rd_en;

  pin_cfg_t             cfg_w  [NUM_PINS];
  logic [DEB_W-1:0]     thr_w  [NUM_PINS];
  logic [NUM_PINS-1:0]  flt_w;
  logic [NUM_PINS-1:0]  oval_w;
  logic [NUM_PINS-1:0]  lvl_w;
  logic [NUM_PINS-1:0]  pend_w;
  logic [NUM_PINS-1:0]  irq_vec;
  logic [DATA_W-1:0]    rd_word;
  logic                 unused_wdata;

  assign win_idx      = addr_i[ADDR_W-1:WIN_SHIFT];
  assign reg_ofs      = addr_i[WIN_SHIFT-1:0];
  assign win_hit      = (win_idx < IDX_W'(NUM_PINS));
  assign wr_en        = req_i & we_i;
  assign rd_en        = req_i & ~we_i;
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t         cfg_q;
    logic [DEB_W-1:0] thr_q;
    logic             flt_q, oval_q;
    logic             wr_sel, clr;

    assign wr_sel = wr_en && win_hit && (win_idx == IDX_W'(i));
    assign clr    = wr_sel && (reg_ofs == OFS_CLR) && wdata_i[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q  <= '0;
        thr_q  <= '0;
        flt_q  <= 1'b0;
        oval_q <= 1'b0;
      end else if (wr_sel) begin
        unique case (reg_ofs)
          OFS_CFG:  cfg_q  <= pin_cfg_t'({wdata_i[6], wdata_i[4:0]});
          OFS_DEB:  thr_q  <= wdata_i[DEB_W-1:0];
          OFS_OCTL: flt_q  <= wdata_i[0];
          OFS_OVAL: oval_q <= wdata_i[0];
          default: ;
        endcase
      end
    end

    gpio_in_filter #(.DEB_W(DEB_W)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pad_i   (pad_i[i]),
      .thr_i   (thr_q),
      .level_o (lvl_w[i])
    );

    gpio_trig_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (lvl_w[i]),
      .trig_i  (cfg_q.trig),
      .pol_i   (cfg_q.pol),
      .clr_i   (clr),
      .pend_o  (pend_w[i])
    );

    assign cfg_w[i]    = cfg_q;
    assign thr_w[i]    = thr_q;
    assign flt_w[i]    = flt_q;
    assign oval_w[i]   = oval_q;
    assign pad_o[i]    = oval_q;
    assign pad_oe_o[i] = cfg_q.en & cfg_q.dir_out & ~flt_q;
    assign irq_vec[i]  = pend_w[i] & cfg_q.irq_en & cfg_q.en;
  end

  assign irq_o = |irq_vec;

  always_comb begin
    rd_word = '0;
    if (addr_i == STATUS_ADDR) begin
      rd_word[NUM_PINS-1:0] = pend_w;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (win_hit && win_idx == IDX_W'(i)) begin
          unique case (reg_ofs)
            OFS_CFG:  rd_word = DATA_W'({cfg_w[i].irq_en, 1'b0, cfg_w[i].pol,
                                         cfg_w[i].trig, cfg_w[i].dir_out, cfg_w[i].en});
            OFS_DEB:  rd_word = DATA_W'(thr_w[i]);
            OFS_IN:   rd_word = DATA_W'(lvl_w[i]);
            OFS_OCTL: rd_word = DATA_W'(flt_w[i]);
            OFS_OVAL: rd_word = DATA_W'(oval_w[i]);
            default:  rd_word = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_word;
  end

  AST_STATUS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr_i == STATUS_ADDR) |=> ((rdata_o >> NUM_PINS) == '0)); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|pend_w)); // R11

  AST_OE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && win_hit && reg_ofs == OFS_OCTL && wdata_i[0]) |=> (pad_oe_o[win_idx[$clog2(NUM_PINS)-1:0]] == 1'b0)); // R3

endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

  localparam int unsigned NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] ra(input int pin, input int ofs);
    return 12'(pin * 32 + ofs);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(ra(0, 'h00), d); check("R1 cfg0", d, 32'h0);
    rd(ra(7, 'h04), d); check("R1 deb7", d, 32'h0);
    rd(12'h100, d);     check("R1 status", d, 32'h0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] d;
    wr(ra(3, 'h00), 32'h5F); rd(ra(3, 'h00), d); check("R2 cfg rw", d, 32'h5F);
    wr(ra(3, 'h00), 32'hFFFF_FFFF); rd(ra(3, 'h00), d); check("R2 cfg mask", d, 32'h5F);
    wr(ra(3, 'h04), 32'h1AB); rd(ra(3, 'h04), d); check("R2 deb", d, 32'hAB);
    rd(ra(2, 'h00), d); check("R2 neighbour", d, 32'h0);
    wr(ra(3, 'h00), 32'h0); wr(ra(3, 'h04), 32'h0);
  endtask

  task automatic t_pad();
    wr(ra(2, 'h10), 32'h1);
    wr(ra(2, 'h00), 32'h3);
    check("R3 oe on", 32'(pad_oe), 32'h04);
    check("R3 level", 32'(pad_out[2]), 32'h1);
    wr(ra(2, 'h0C), 32'h1);
    check("R3 float", 32'(pad_oe), 32'h0);
    wr(ra(2, 'h0C), 32'h0);
    wr(ra(2, 'h00), 32'h2);
    check("R3 disabled", 32'(pad_oe), 32'h0);
    wr(ra(2, 'h00), 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pad_in[5] = 1'b1; idle(5);
    rd(ra(5, 'h08), d); check("R4 in high", d, 32'h1);
    pad_in[5] = 1'b0; idle(5);
    rd(ra(5, 'h08), d); check("R4 in low", d, 32'h0);
  endtask

  task automatic t_debounce_edge();
    wr(ra(1, 'h04), 32'h3);
    wr(ra(1, 'h00), 32'h59);            // en, single edge, rising, ie
    @(negedge clk); pad_in[1] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); pad_in[1] = 1'b0;
    idle(12);
    check("R5 glitch dropped", 32'(irq), 32'h0);
    pad_in[1] = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk); check("R5 not yet", 32'(irq), 32'h0);
    @(posedge clk);
    @(negedge clk); check("R5 accepted", 32'(irq), 32'h1);
    idle(20); check("R6 latched", 32'(irq), 32'h1);
    wr(ra(1, 'h14), 32'h0); check("R9 zero write", 32'(irq), 32'h1);
    wr(ra(1, 'h14), 32'h1); check("R9 cleared", 32'(irq), 32'h0);
    wr(ra(1, 'h00), 32'h49);            // falling
    idle(3); check("R6 no spurious", 32'(irq), 32'h0);
    pad_in[1] = 1'b0; idle(12);
    check("R6 falling", 32'(irq), 32'h1);
    wr(ra(1, 'h14), 32'h1);
    pad_in[1] = 1'b1; idle(12);
    check("R6 rise ignored", 32'(irq), 32'h0);
    wr(ra(1, 'h00), 32'h0); pad_in[1] = 1'b0; idle(12);
    wr(ra(1, 'h14), 32'h1);
  endtask

  task automatic t_double();
    logic [31:0] d;
    wr(ra(4, 'h00), 32'h4D);
    pad_in[4] = 1'b1; idle(6);
    rd(12'h100, d); check("R7 rise", d, 32'h10);
    check("R10 irq", 32'(irq), 32'h1);
    wr(ra(4, 'h14), 32'h1);
    pad_in[4] = 1'b0; idle(6);
    rd(12'h100, d); check("R7 fall", d, 32'h10);
    wr(ra(4, 'h14), 32'h1);
    rd(12'h100, d); check("R10 empty", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(ra(4, 'h00), 32'h0D);
    pad_in[4] = 1'b1; idle(6);
    rd(12'h100, d); check("R11 pend unmasked", d, 32'h10);
    check("R11 ie off", 32'(irq), 32'h0);
    wr(ra(4, 'h00), 32'h4D); check("R11 ie on", 32'(irq), 32'h1);
    wr(ra(4, 'h00), 32'h4C); check("R11 en off", 32'(irq), 32'h0);
    rd(12'h100, d); check("R11 pend kept", d, 32'h10);
    wr(ra(4, 'h00), 32'h0); wr(ra(4, 'h14), 32'h1);
    pad_in[4] = 1'b0; idle(4);
  endtask

  task automatic t_level();
    wr(ra(6, 'h00), 32'h55);            // level, active high
    idle(3); check("R8 inactive", 32'(irq), 32'h0);
    pad_in[6] = 1'b1; idle(6);
    check("R8 high", 32'(irq), 32'h1);
    wr(ra(6, 'h14), 32'h1);
    check("R8 clear cycle", 32'(irq), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 rearm", 32'(irq), 32'h1);
    pad_in[6] = 1'b0; idle(6);
    wr(ra(6, 'h14), 32'h1); idle(2);
    check("R8 gone", 32'(irq), 32'h0);
    wr(ra(6, 'h00), 32'h45);            // active low
    idle(2); check("R8 low", 32'(irq), 32'h1);
    wr(ra(6, 'h00), 32'h0); wr(ra(6, 'h14), 32'h1);
  endtask

  task automatic t_none();
    logic [31:0] d;
    wr(ra(7, 'h00), 32'h41);
    pad_in[7] = 1'b1; idle(6);
    pad_in[7] = 1'b0; idle(6);
    rd(12'h100, d); check("R12 status", d, 32'h0);
    check("R12 irq", 32'(irq), 32'h0);
    wr(ra(7, 'h00), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_cfg_rw();
    t_pad();
    t_input();
    t_debounce_edge();
    t_double();
    t_mask();
    t_level();
    t_none();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule